// File: doc/BRIEF.md
# Task-Driven Capture/Compare Timer

This block is a timer/counter peripheral on a simple 32-bit register bus with an address, a write enable, write data and combinational read data. Software does not load the counter. It pulses write-only task registers to start, stop, step, zero or power down the counter, or to snapshot it into one of four capture/compare registers.

Each channel compares the running counter with the low bits of its own register. On a match it latches a sticky event flag. Per-channel shortcut bits can route that match straight into the zero or halt action in hardware, with no software step in between. Interrupt enables are written through separate set and clear addresses, and one interrupt line combines all enabled pending events.

The counter advances on a power-of-two prescaled clock in timer mode, or on each step task in counter mode. It wraps at a selectable width of 8, 16, 24 or 32 bits.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, the width, mode, prescaler, interrupt-enable (0x304), shortcut (0x200) and CC registers read 0, every event reads 0, and irqOut is 0.
- R2: Writing 1 to 0x000 starts the counter and writing 1 to 0x004 halts it. In timer mode (0x504 bit 0 = 0), a counter started from a zeroed prescaler phase advances by floor(k / 2^p) over k cycles, where p is the prescaler. The cycle in which a halt is written adds no increment, and a halted counter holds its value.
- R3: The prescaler at 0x510 reads back the written value, and any value above 9 is stored as 9.
- R4: In counter mode (0x504 bit 0 = 1), each write of 1 to 0x008 adds one while the counter runs. The same write has no effect in timer mode or while halted.
- R5: Width code 0x508 bits [1:0] select the counter width as 0 = 16, 1 = 8, 2 = 24 and 3 = 32 bits. The counter wraps at that width, and compares use only that many low bits of CC[n].
- R6: Writing 1 to 0x00C makes the counter 0 on the next cycle and leaves the running state unchanged. A zeroing action wins over an increment in the same cycle.
- R7: Writing 1 to 0x040+4n copies the counter into CC[n]. CC[n] at 0x540+4n is read/write.
- R8: While running, a counter equal to the masked CC[n] sets event n (0x140+4n reads 1). The event stays set until a write with bit 0 = 0 clears it, and a new match in the same cycle wins.
- R9: Shortcut bit n (0x200) zeroes the counter in the cycle after a channel-n match.
- R10: Shortcut bit 8+n halts the counter on a channel-n match, with no increment in that cycle.
- R11: Writing 1 to bit 16+n at 0x304 enables channel n, and writing 1 to bit 16+n at 0x308 disables it. Zero bits have no effect, and both addresses read the enable mask.
- R12: irqOut is high exactly when some channel has its event pending and its enable set.
- R13: Writing 1 to 0x010 halts the counter and resets the prescaler phase to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Register byte address |
| busWe | input | 1 | Write enable, one write per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions assume at most one register access per cycle, and they assume that the counter value changes only on bus writes or while the counter runs. A halted counter is therefore expected to hold steady whenever busWe is low. The stimulus drives each write for exactly one clock and leaves busWe low between writes. Before each timed run it issues a power-down and a zeroing write, so the prescaler phase starts at zero and the expected count can be computed in closed form. Random runs draw the width code, prescaler and run length from a fixed seed, with long runs in 8-bit mode to force wrapping. Directed cases cover the two shortcut kinds, event clearing, enable gating and prescaler phase reset.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int NUM_CH    = 4;
  localparam int CNT_W     = 32;
  localparam int ADDR_W    = 12;
  localparam int PSC_W     = 4;
  localparam int PSC_MAX   = 9;
  localparam int PRE_W     = PSC_MAX;
  localparam int STOP_BASE = 8;
  localparam int IEN_BASE  = 16;

  localparam logic [ADDR_W-1:0] OFF_START  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_HALT   = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_STEP   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_ZERO   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_PWRDN  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_SNAP   = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_EVT    = 12'h140;
  localparam logic [ADDR_W-1:0] OFF_LINK   = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_IENSET = 12'h304;
  localparam logic [ADDR_W-1:0] OFF_IENCLR = 12'h308;
  localparam logic [ADDR_W-1:0] OFF_MODE   = 12'h504;
  localparam logic [ADDR_W-1:0] OFF_WIDTH  = 12'h508;
  localparam logic [ADDR_W-1:0] OFF_PSC    = 12'h510;
  localparam logic [ADDR_W-1:0] OFF_CC     = 12'h540;

  typedef enum logic [1:0] {
    WID16 = 2'd0,
    WID8  = 2'd1,
    WID24 = 2'd2,
    WID32 = 2'd3
  } widthSel_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic              start;
    logic              halt;
    logic              step;
    logic              zero;
    logic              pwrDown;
    logic [NUM_CH-1:0] snap;
    logic [NUM_CH-1:0] ccWrite;
  } taskStrobe_t;

  function automatic logic [CNT_W-1:0] widthMask(widthSel_t w);
    case (w)
      WID8:    return 32'h0000_00FF;
      WID24:   return 32'h00FF_FFFF;
      WID32:   return 32'hFFFF_FFFF;
      default: return 32'h0000_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  taskStrobe_t                   stb,
  input  logic                          modeCounter,
  input  widthSel_t                     widthCode,
  input  logic [PSC_W-1:0]              pscVal,
  input  logic [NUM_CH-1:0]             linkZero,
  input  logic [NUM_CH-1:0]             linkHalt,
  input  logic [CNT_W-1:0]              wrData,
  output logic [CNT_W-1:0]              cntVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]  ccVals,
  output logic [NUM_CH-1:0]             hitVec,
  output logic                          running
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] mask;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] pscMask;
  logic             preTick;
  logic             haltNow;
  logic             zeroNow;
  logic             incNow;

  assign mask    = widthMask(widthCode);
  assign cntVal  = cntQ & mask;
  assign pscMask = PRE_W'((32'd1 << pscVal) - 32'd1);
  assign preTick = (preCnt & pscMask) == pscMask;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gCh
      assign hitVec[g] = running && (cntVal == (ccVals[g] & mask));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             ccVals[g] <= '0;
        else if (stb.snap[g])   ccVals[g] <= cntVal;
        else if (stb.ccWrite[g]) ccVals[g] <= wrData;
      end
    end
  endgenerate

  assign haltNow = stb.halt | stb.pwrDown | (|(hitVec & linkHalt));
  assign zeroNow = stb.zero | (|(hitVec & linkZero));
  assign incNow  = running && !haltNow && (modeCounter ? stb.step : preTick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      preCnt  <= '0;
      cntQ    <= '0;
    end else begin
      if (haltNow)        running <= 1'b0;
      else if (stb.start) running <= 1'b1;

      if (stb.pwrDown)                    preCnt <= '0;
      else if (running && !modeCounter)   preCnt <= preCnt + 1'b1;

      if (zeroNow)     cntQ <= '0;
      else if (incNow) cntQ <= (cntVal + 1'b1) & mask;
    end
  end
endmodule

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWe,
  input  logic [31:0]                   busWdata,
  input  logic [NUM_CH-1:0]             hitVec,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  ccVals,
  output taskStrobe_t                   stb,
  output logic                          modeCounter,
  output widthSel_t                     widthCode,
  output logic [PSC_W-1:0]              pscVal,
  output logic [NUM_CH-1:0]             linkZero,
  output logic [NUM_CH-1:0]             linkHalt,
  output logic [NUM_CH-1:0]             evVec,
  output logic [NUM_CH-1:0]             ienVec,
  output logic [31:0]                   busRdata,
  output logic                          irqOut
);
  logic wrLsb;
  assign wrLsb = busWdata[0];

  always_comb begin
    stb = '0;
    if (busWe) begin
      stb.start   = (busAddr == OFF_START) && wrLsb;
      stb.halt    = (busAddr == OFF_HALT)  && wrLsb;
      stb.step    = (busAddr == OFF_STEP)  && wrLsb;
      stb.zero    = (busAddr == OFF_ZERO)  && wrLsb;
      stb.pwrDown = (busAddr == OFF_PWRDN) && wrLsb;
      for (int i = 0; i < NUM_CH; i++) begin
        stb.snap[i]    = (busAddr == ADDR_W'(OFF_SNAP + 4 * i)) && wrLsb;
        stb.ccWrite[i] = (busAddr == ADDR_W'(OFF_CC + 4 * i));
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gEvt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           evVec[g] <= 1'b0;
        else if (hitVec[g])   evVec[g] <= 1'b1;
        else if (busWe && busAddr == ADDR_W'(OFF_EVT + 4 * g) && !wrLsb)
                              evVec[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeCounter <= 1'b0;
      widthCode   <= WID16;
      pscVal      <= '0;
      linkZero    <= '0;
      linkHalt    <= '0;
      ienVec      <= '0;
    end else if (busWe) begin
      case (busAddr)
        OFF_MODE:  modeCounter <= wrLsb;
        OFF_WIDTH: widthCode   <= widthSel_t'(busWdata[1:0]);
        OFF_PSC:   pscVal      <= (busWdata > 32'(PSC_MAX)) ? PSC_W'(PSC_MAX)
                                                            : busWdata[PSC_W-1:0];
        OFF_LINK: begin
          linkZero <= busWdata[NUM_CH-1:0];
          linkHalt <= busWdata[STOP_BASE +: NUM_CH];
        end
        OFF_IENSET: ienVec <= ienVec | busWdata[IEN_BASE +: NUM_CH];
        OFF_IENCLR: ienVec <= ienVec & ~busWdata[IEN_BASE +: NUM_CH];
        default: ;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFF_MODE:  busRdata = {31'b0, modeCounter};
      OFF_WIDTH: busRdata = {30'b0, widthCode};
      OFF_PSC:   busRdata = 32'(pscVal);
      OFF_LINK: begin
        busRdata[NUM_CH-1:0]            = linkZero;
        busRdata[STOP_BASE +: NUM_CH]   = linkHalt;
      end
      OFF_IENSET, OFF_IENCLR: busRdata[IEN_BASE +: NUM_CH] = ienVec;
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(OFF_EVT + 4 * i)) busRdata = {31'b0, evVec[i]};
      if (busAddr == ADDR_W'(OFF_CC + 4 * i))  busRdata = ccVals[i];
    end
  end

  assign irqOut = |(evVec & ienVec);
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);
  taskStrobe_t                  stb;
  logic                         modeCounter;
  widthSel_t                    widthCode;
  logic [PSC_W-1:0]             pscVal;
  logic [NUM_CH-1:0]            linkZero;
  logic [NUM_CH-1:0]            linkHalt;
  logic [NUM_CH-1:0]            evVec;
  logic [NUM_CH-1:0]            ienVec;
  logic [NUM_CH-1:0]            hitVec;
  logic [NUM_CH-1:0][CNT_W-1:0] ccVals;
  logic [CNT_W-1:0]             cntVal;
  logic                         running;

  capcmp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .hitVec(hitVec), .ccVals(ccVals), .stb(stb),
    .modeCounter(modeCounter), .widthCode(widthCode), .pscVal(pscVal),
    .linkZero(linkZero), .linkHalt(linkHalt), .evVec(evVec),
    .ienVec(ienVec), .busRdata(busRdata), .irqOut(irqOut)
  );

  capcmp_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .modeCounter(modeCounter),
    .widthCode(widthCode), .pscVal(pscVal), .linkZero(linkZero),
    .linkHalt(linkHalt), .wrData(busWdata), .cntVal(cntVal),
    .ccVals(ccVals), .hitVec(hitVec), .running(running)
  );
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk
  import capcmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              wdataLsb,
  input logic              irqOut,
  input logic [NUM_CH-1:0] evVec,
  input logic [NUM_CH-1:0] hitVec,
  input logic [NUM_CH-1:0] linkHalt,
  input logic [CNT_W-1:0]  cntVal,
  input logic              running
);
  // R8: pending events never drop without a bus write
  assert_event_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busWe |=> ((evVec & $past(evVec)) == $past(evVec)));

  // R6: a zeroing write leaves the counter at zero next cycle
  assert_zero_task_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == OFF_ZERO && wdataLsb) |=> (cntVal == '0));

  // R10: a linked halt match stops the counter
  assert_link_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hitVec & linkHalt)) |=> !running);

  // R2: a halted counter with an idle bus holds its value
  assert_halted_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !busWe) |=> $stable(cntVal));

  // R12: the interrupt line needs a pending event
  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (|evVec));
endmodule

bind capcmp_timer capcmp_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
  .wdataLsb(busWdata[0]), .irqOut(irqOut), .evVec(evVec),
  .hitVec(hitVec), .linkHalt(linkHalt), .cntVal(cntVal), .running(running)
);

// File: tb/capcmp_timer_tb.sv
module capcmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  int checks = 0;
  int fails = 0;

  always #10ns clk = ~clk;

  capcmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic logic [31:0] maskOf(int w);
    case (w)
      1: return 32'h0000_00FF;
      2: return 32'h00FF_FFFF;
      3: return 32'hFFFF_FFFF;
      default: return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] expCount(int k, int p, int w);
    return 32'(k >> p) & maskOf(w);
  endfunction

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic cntChk(input string tag, input logic [31:0] exp);
    wr(12'h040, 1);
    rdChk(tag, 12'h540, exp);
  endtask

  task automatic timedRun(input int k);
    wr(12'h010, 1); wr(12'h00C, 1); wr(12'h000, 1);
    idle(k);
    wr(12'h004, 1);
  endtask

  initial begin
    #(20ns * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rdChk("R1 width", 12'h508, 0);
    rdChk("R1 mode", 12'h504, 0);
    rdChk("R1 psc", 12'h510, 0);
    rdChk("R1 ien", 12'h304, 0);
    rdChk("R1 link", 12'h200, 0);
    rdChk("R1 cc1", 12'h544, 0);
    rdChk("R1 evt0", 12'h140, 0);
    check("R1 irq", 32'(irqOut), 0);

    // R3 prescaler clamp
    wr(12'h510, 3);  rdChk("R3 psc3", 12'h510, 3);
    wr(12'h510, 15); rdChk("R3 clamp", 12'h510, 9);
    wr(12'h510, 0);

    // R2 timer mode, halt blocks its own cycle, halted holds
    timedRun(10);
    cntChk("R2 run10", 10);
    idle(5);
    cntChk("R2 hold", 10);

    // R2 prescaler 2
    wr(12'h510, 2);
    timedRun(9);
    cntChk("R2 psc2", 2);

    // R13 power-down resets phase (stale phase would give 1)
    timedRun(3);
    cntChk("R13 phase", 0);
    wr(12'h510, 0);
    wr(12'h010, 1); wr(12'h00C, 1); wr(12'h000, 1);
    idle(3);
    wr(12'h010, 1);
    idle(5);
    cntChk("R13 halts", 3);

    // R6 zero while running, running kept
    wr(12'h00C, 1); wr(12'h000, 1);
    idle(5);
    wr(12'h00C, 1);
    cntChk("R6 zeroed", 0);
    idle(4);
    wr(12'h004, 1);
    cntChk("R6 still running", 5);

    // R4 counter mode
    wr(12'h504, 1);
    wr(12'h00C, 1); wr(12'h000, 1);
    wr(12'h008, 1); wr(12'h008, 1); wr(12'h008, 1);
    idle(5);
    wr(12'h004, 1);
    cntChk("R4 steps", 3);
    wr(12'h008, 1);
    cntChk("R4 halted step", 3);
    wr(12'h504, 0);
    wr(12'h008, 1);
    cntChk("R4 timer-mode step", 3);

    // R7 CC read/write
    wr(12'h54C, 32'hDEAD_BEEF);
    rdChk("R7 cc3 rw", 12'h54C, 32'hDEAD_BEEF);

    // R5 8-bit wrap
    wr(12'h508, 1);
    timedRun(260);
    cntChk("R5 wrap8", 4);
    wr(12'h508, 0);

    // R8/R11/R12 compare on low bits, event, irq
    for (int i = 0; i < 4; i++) wr(12'(12'h140 + 4 * i), 0);
    wr(12'h544, 32'h0001_0005);
    wr(12'h304, 32'h0002_0000);
    wr(12'h304, 32'h0000_0000);
    rdChk("R11 set", 12'h308, 32'h0002_0000);
    wr(12'h00C, 1); wr(12'h000, 1);
    idle(3);
    rdChk("R8 not yet", 12'h144, 0);
    check("R12 idle irq", 32'(irqOut), 0);
    idle(5);
    rdChk("R8 hit", 12'h144, 1);
    check("R12 irq up", 32'(irqOut), 1);
    wr(12'h004, 1);
    wr(12'h144, 0);
    rdChk("R8 cleared", 12'h144, 0);
    check("R12 irq down", 32'(irqOut), 0);
    timedRun(10);
    check("R12 irq again", 32'(irqOut), 1);
    wr(12'h308, 32'h0002_0000);
    rdChk("R11 cleared", 12'h304, 0);
    rdChk("R8 still pending", 12'h144, 1);
    check("R12 masked", 32'(irqOut), 0);

    // R10 link halt on channel 2
    wr(12'h548, 7);
    wr(12'h200, 32'h0000_0400);
    rdChk("R10 link rd", 12'h200, 32'h0000_0400);
    timedRun(20);
    cntChk("R10 halted at 7", 7);
    rdChk("R10 evt2", 12'h148, 1);

    // R9 link zero on channel 3
    wr(12'h54C, 4);
    wr(12'h200, 32'h0000_0008);
    timedRun(13);
    cntChk("R9 modulo", 3);
    wr(12'h200, 0);

    // R2/R5 random runs
    for (int it = 0; it < 25; it++) begin
      int w = int'($urandom % 4);
      int p = int'($urandom % 4);
      int k = int'($urandom % ((w == 1) ? 700 : 120));
      wr(12'h508, 32'(w));
      wr(12'h510, 32'(p));
      timedRun(k);
      cntChk($sformatf("R2 R5 random w%0d p%0d k%0d", w, p, k), expCount(k, p, w));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule